// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes five interrupt request lines and, whenever the processor signals that an instruction has finished, picks at most one of them for service. One request cannot be masked. Three maskable requests each have a fixed 16-bit restart address. The fifth request is the lowest-priority general request. It carries no address of its own, so the block answers it with an active-low acknowledge strobe, and the device that raised it supplies the instruction.

Software controls the block through a single register write port. One write can set or clear the global enable, load the three per-line mask bits, and discard a latched 7.5 request. When a request is accepted, the block gives a one-cycle accept pulse, the restart address, and a flag that says whether the address must come from outside. The block does not stack the program counter, fetch opcodes or run the handler.

Top module: `vecint_ctrl`

## Requirements
- R1: When several requests are eligible at the same boundary, the winner is the first one in this order: non-maskable, 7.5, 6.5, 5.5, general.
- R2: An accepted non-maskable request gives vector 0x0024. It is accepted whatever the mask bits and the global enable hold.
- R3: An accepted 7.5 request gives vector 0x003C, a 6.5 request gives 0x0034 and a 5.5 request gives 0x002C. In each case the external flag is 0.
- R4: A maskable request is taken only while the global enable is 1 and its own mask bit is 0. The write word (7 bits) is laid out as: bit6 = enable-write, bit5 = enable value, bit4 = discard the 7.5 latch, bit3 = mask-write, bit2/bit1/bit0 = mask for 7.5/6.5/5.5 (1 blocks). The general request is gated by the global enable alone.
- R5: An accepted general request gives vector 0, sets the external flag to 1, and drives the acknowledge low for exactly the accept cycle.
- R6: Arbitration happens only in a cycle where the boundary strobe is high. Accept, vector, flag and acknowledge change on the next clock edge. With the strobe low, accept stays 0 and the acknowledge stays high.
- R7: The 7.5 request is caught on a rising edge and stays pending while it is masked. The pending state clears when the request is serviced or when a write sets bit4.
- R8: The 6.5 and 5.5 requests are level-sensitive. A level that drops before the boundary is not serviced.
- R9: Accepting a maskable request clears the global enable. Accepting the non-maskable request leaves the enable unchanged.
- R10: The non-maskable request is caught on a rising edge and cleared when it is accepted. One pulse gives exactly one service.
- R11: After reset, accept and the external flag are 0, the vector is 0, the acknowledge is high, every mask bit is set, the global enable is 0 and no latch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, rising-edge caught |
| req75 | input | 1 | 7.5 request, rising-edge caught |
| req65 | input | 1 | 6.5 request, level |
| req55 | input | 1 | 5.5 request, level |
| gen_req | input | 1 | General non-vectored request, level |
| boundary | input | 1 | Instruction-boundary strobe |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 7 | Control write word |
| accept | output | 1 | One-cycle accept pulse |
| vector | output | 16 | Restart address of the accepted request |
| vec_ext | output | 1 | Vector must be supplied externally |
| ack_n | output | 1 | Active-low acknowledge for the general request |

## Verification
The hardest state to reach from the ports is a 7.5 request that is latched while masked and later serviced ahead of a 5.5 level that is still active. The stimulus creates it in steps. First it masks only the 7.5 line and pulses it, so a boundary services the 5.5 request instead. Then it unmasks the 7.5 line and re-enables, and expects 0x003C at the next boundary. The bench also pulses the non-maskable and 7.5 lines together, and checks that the enable survives the non-maskable service so that the pending 7.5 request follows at the next boundary.

// File: rtl/vecint_pkg.sv
package vecint_pkg;

    localparam int VEC_W = 16;
    localparam int NMASK = 3;

    // control write word, MSB first
    typedef struct packed {
        logic             en_wr;
        logic             en_val;
        logic             clr75;
        logic             mask_wr;
        logic [NMASK-1:0] mask;   // [2]=7.5 [1]=6.5 [0]=5.5
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_R75,
        SRC_R65,
        SRC_R55,
        SRC_GEN
    } src_e;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75 = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65 = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55 = 16'h002C;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_NMI: return VEC_NMI;
            SRC_R75: return VEC_R75;
            SRC_R65: return VEC_R65;
            SRC_R55: return VEC_R55;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/vecint_edge_latch.sv
module vecint_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic clr,
    output logic pend
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= din;
            if (din && !prev_q)
                pend <= 1'b1;      // a fresh edge wins over a clear
            else if (clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/vecint_prio.sv
module vecint_prio
    import vecint_pkg::*;
(
    input  logic             nmi_p,
    input  logic             r75_p,
    input  logic             r65,
    input  logic             r55,
    input  logic             gen,
    input  logic             ie,
    input  logic [NMASK-1:0] mask,
    output src_e             sel
);
    always_comb begin
        if (nmi_p)                   sel = SRC_NMI;
        else if (ie && r75_p && !mask[2]) sel = SRC_R75;
        else if (ie && r65 && !mask[1])   sel = SRC_R65;
        else if (ie && r55 && !mask[0])   sel = SRC_R55;
        else if (ie && gen)               sel = SRC_GEN;
        else                              sel = SRC_NONE;
    end
endmodule

// File: rtl/vecint_ctrl.sv
module vecint_ctrl
    import vecint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_req,
    input  logic             req75,
    input  logic             req65,
    input  logic             req55,
    input  logic             gen_req,
    input  logic             boundary,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             accept,
    output logic [VEC_W-1:0] vector,
    output logic             vec_ext,
    output logic             ack_n
);
    cfg_t             cfg;
    logic             ie_q;
    logic [NMASK-1:0] mask_q;
    logic             nmi_pend, r75_pend;
    logic             take;
    src_e             sel;

    assign cfg  = cfg_t'(cfg_wdata);
    assign take = boundary && (sel != SRC_NONE);

    vecint_edge_latch u_nmi_latch (
        .clk (clk),
        .rst (rst),
        .din (nmi_req),
        .clr (take && sel == SRC_NMI),
        .pend(nmi_pend)
    );

    vecint_edge_latch u_r75_latch (
        .clk (clk),
        .rst (rst),
        .din (req75),
        .clr ((take && sel == SRC_R75) || (cfg_we && cfg.clr75)),
        .pend(r75_pend)
    );

    vecint_prio u_prio (
        .nmi_p(nmi_pend),
        .r75_p(r75_pend),
        .r65  (req65),
        .r55  (req55),
        .gen  (gen_req),
        .ie   (ie_q),
        .mask (mask_q),
        .sel  (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q    <= 1'b0;
            mask_q  <= '1;
            accept  <= 1'b0;
            vector  <= '0;
            vec_ext <= 1'b0;
            ack_n   <= 1'b1;
        end else begin
            accept  <= take;
            vector  <= take ? vec_of(sel) : '0;
            vec_ext <= take && (sel == SRC_GEN);
            ack_n   <= !(take && (sel == SRC_GEN));
            if (cfg_we && cfg.mask_wr)
                mask_q <= cfg.mask;
            if (take && sel != SRC_NMI)
                ie_q <= 1'b0;
            if (cfg_we && cfg.en_wr)
                ie_q <= cfg.en_val;
        end
    end
endmodule

// File: rtl/vecint_ctrl_chk.sv
module vecint_ctrl_chk
    import vecint_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             boundary,
    input logic             cfg_we,
    input logic             accept,
    input logic [VEC_W-1:0] vector,
    input logic             vec_ext,
    input logic             ack_n,
    input logic             ie
);
    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(boundary)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !accept |-> (ack_n && !vec_ext)); // R6

    AST_ACK_GEN_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> (accept && vec_ext && vector == '0)); // R5

    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (accept && !vec_ext) |-> (vector == VEC_NMI || vector == VEC_R75 ||
                                  vector == VEC_R65 || vector == VEC_R55)); // R3

    AST_MASKABLE_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (accept && vector != VEC_NMI) |-> $past(ie)); // R4

    AST_IE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (accept && vector != VEC_NMI && !$past(cfg_we)) |-> !ie); // R9
endmodule

bind vecint_ctrl vecint_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .boundary(boundary),
    .cfg_we  (cfg_we),
    .accept  (accept),
    .vector  (vector),
    .vec_ext (vec_ext),
    .ack_n   (ack_n),
    .ie      (ie_q)
);

// File: tb/vecint_ctrl_bench.sv
module vecint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 1'b0, req75 = 1'b0, req65 = 1'b0, req55 = 1'b0, gen_req = 1'b0;
    logic        boundary = 1'b0, cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        accept, vec_ext, ack_n;
    logic [15:0] vector;

    int checks = 0, errors = 0;
    bit done = 0;

    logic        q_acc[$];
    logic [15:0] q_vec[$];
    logic        q_ext[$];
    string       q_req[$];
    event        ev_sample;

    always #5 clk = ~clk;

    vecint_ctrl u_vecint_ctrl (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .req75(req75), .req65(req65),
        .req55(req55), .gen_req(gen_req), .boundary(boundary), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .accept(accept), .vector(vector),
        .vec_ext(vec_ext), .ack_n(ack_n)
    );

    // monitor: pops one expectation per sample event
    initial begin
        forever begin
            @(ev_sample);
            begin
                logic        ea, ee;
                logic [15:0] ev;
                string       er;
                ea = q_acc.pop_front(); ev = q_vec.pop_front();
                ee = q_ext.pop_front(); er = q_req.pop_front();
                checks++;
                if (accept !== ea || vector !== ev || vec_ext !== ee || ack_n !== !(ea && ee)) begin
                    errors++;
                    $display("FAIL %s: got acc=%b vec=%h ext=%b ack_n=%b, want acc=%b vec=%h ext=%b ack_n=%b",
                             er, accept, vector, vec_ext, ack_n, ea, ev, ee, !(ea && ee));
                end
            end
        end
    end

    // driver: queue expectation, present strobe, sample after the edge
    task automatic step(input logic bnd, input logic acc, input logic [15:0] vec,
                        input logic ext, input string req);
        q_acc.push_back(acc); q_vec.push_back(vec);
        q_ext.push_back(ext); q_req.push_back(req);
        @(negedge clk) boundary = bnd;
        @(posedge clk); #1;
        ->ev_sample;
        @(negedge clk) boundary = 1'b0;
    endtask

    task automatic cfgw(input logic [6:0] w);
        @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = w; end
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic do_nmi, input logic do_75);
        @(negedge clk) begin nmi_req = do_nmi; req75 = do_75; end
        @(negedge clk) begin nmi_req = 1'b0; req75 = 1'b0; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11 reset state
        checks++;
        if (accept !== 1'b0 || vector !== 16'h0 || vec_ext !== 1'b0 || ack_n !== 1'b1) begin
            errors++;
            $display("FAIL R11: got acc=%b vec=%h ext=%b ack_n=%b, want 0 0000 0 1",
                     accept, vector, vec_ext, ack_n);
        end
        // R11/R4: masked and disabled after reset
        req65 = 1'b1; gen_req = 1'b1;
        step(1, 0, 16'h0000, 0, "R11 masked after reset");
        // R2: non-maskable taken with enable off
        pulse(1, 0);
        step(1, 1, 16'h0024, 0, "R2 nmi vector");
        step(1, 0, 16'h0000, 0, "R10 one pulse one service");
        // R1/R3: 6.5 beats general
        cfgw(7'h68);
        step(1, 1, 16'h0034, 0, "R1 6.5 over general");
        step(1, 0, 16'h0000, 0, "R9 enable cleared");
        cfgw(7'h60);
        step(0, 0, 16'h0000, 0, "R6 no strobe no accept");
        step(1, 1, 16'h0034, 0, "R3 6.5 vector");
        // R5: general request
        req65 = 1'b0;
        cfgw(7'h60);
        step(1, 1, 16'h0000, 1, "R5 general acknowledge");
        step(0, 0, 16'h0000, 0, "R5 acknowledge released");
        // R7: 7.5 latched while masked
        gen_req = 1'b0;
        cfgw(7'h6C);
        pulse(0, 1);
        req55 = 1'b1;
        step(1, 1, 16'h002C, 0, "R4 masked 7.5 skipped");
        cfgw(7'h68);
        step(1, 1, 16'h003C, 0, "R7 pending 7.5 over 5.5");
        cfgw(7'h60);
        step(1, 1, 16'h002C, 0, "R7 7.5 cleared by service");
        // R7: discard by write
        req55 = 1'b0;
        cfgw(7'h6C);
        pulse(0, 1);
        step(1, 0, 16'h0000, 0, "R4 7.5 masked pending");
        cfgw(7'h78);
        step(1, 0, 16'h0000, 0, "R7 discard bit clears latch");
        // R1/R9: nmi over 7.5, enable survives nmi
        pulse(1, 1);
        step(1, 1, 16'h0024, 0, "R1 nmi over 7.5");
        step(1, 1, 16'h003C, 0, "R9 enable kept after nmi");
        // R8: level dropped before boundary
        cfgw(7'h60);
        @(negedge clk) req55 = 1'b1;
        @(negedge clk) req55 = 1'b0;
        step(1, 0, 16'h0000, 0, "R8 dropped level ignored");
        req55 = 1'b1;
        step(1, 1, 16'h002C, 0, "R8 held level taken");
        req55 = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule